// File: doc/BRIEF.md
# Indexed Instruction Address Generator

This block runs the fetch half of a simple single-address processor. On a start pulse it reads the instruction word at the program counter from a synchronous memory port and advances the counter by one. It then splits the 20-bit word into an operation code, a two-bit index selector and a 13-bit address field, and produces the effective operand address that the execution stage will use.

The index registers are not flip-flops. They are the memory words at addresses 1, 2 and 3. When the selector is non-zero, the block issues one extra memory read of the chosen word and adds its low 13 bits to the address field. The sum wraps modulo 8192. When the result is ready, a one-cycle done strobe is raised. The operation code and effective address then hold until the next start pulse.

A start pulse that arrives with the jump request set first loads the counter from the address field of the instruction fetched last, and then fetches from there. This is how a branch is carried out.

Top module: `idx_fetch_agu`

## Requirements
- R1: After reset, `done` and `memRdEn` are low and `pcOut` equals the parameter `RESET_PC` (default 16).
- R2: A fetched word is split MSB first: `opcode` is bits 19..15, the index selector is bits 14..13, and the address field is bits 12..0.
- R3: With selector 00, `effAddr` equals the address field. `done` rises in the third cycle after the clock edge that samples `start`.
- R4: Selectors 01, 10 and 11 cause a read of memory address 1, 2 or 3 respectively. `effAddr` is then the address field plus bits 12..0 of that word, modulo 8192.
- R5: An indexed instruction takes exactly one cycle more than an unindexed one, so `done` rises in the fourth cycle after `start` is sampled.
- R6: Each fetch reads the word at the program counter and increments the counter by one, wrapping from 8191 to 0. `pcOut` shows the next sequential address once `done` is seen.
- R7: A `start` with `jumpEn` high loads the counter from the raw (unindexed) address field of the last fetched instruction, and the fetch then reads from that address.
- R8: `done` lasts exactly one cycle. `opcode` and `effAddr` hold their values until a later `start`.
- R9: A `start` pulse while a fetch is in progress is ignored. It produces no extra fetch, no extra `done` and no counter change.
- R10: `memRdEn` is high only in the instruction-read cycle and, for indexed words, in the index-read cycle that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one fetch when idle |
| jumpEn | input | 1 | With `start`: load counter from last address field first |
| memRdEn | output | 1 | Memory read request |
| memAddr | output | 13 | Memory read address |
| memRdData | input | 20 | Read data, valid the cycle after `memRdEn` |
| opcode | output | 5 | Operation code of the last fetched word |
| effAddr | output | 13 | Effective operand address |
| done | output | 1 | One-cycle completion strobe |
| pcOut | output | 13 | Current program counter |

## Verification
The cycle that returns the instruction word is also the cycle that must decide whether to issue the index read. So the instruction-register load and the index-memory request coincide, and both are driven from the same incoming data. The bench provokes this with each non-zero selector and judges it by the address sum and by the one-cycle latency penalty. A second collision is provoked by pulsing `start` during an active fetch. That case is judged by the absence of a second `done` and by an unchanged counter.

// File: rtl/idx_fetch_pkg.sv
package idx_fetch_pkg;
  localparam int WORD_W = 20;
  localparam int ADDR_W = 13;
  localparam int OP_W   = 5;
  localparam int SEL_W  = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_LATCH, S_INDEX, S_DONE
  } fetchState_t;

  typedef struct packed {
    logic pcLoadJump;
    logic pcIncr;
    logic fetchRd;
    logic irLoad;
    logic indexRd;
    logic effLoadDirect;
    logic effLoadIndexed;
  } fetchStrobes_t;
endpackage

// File: rtl/idx_fetch_ctrl.sv
module idx_fetch_ctrl
  import idx_fetch_pkg::*;
#(
  parameter int SEL_W_P = SEL_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               jumpEn,
  input  logic [SEL_W_P-1:0] incomingSel,
  output fetchStrobes_t      strobes,
  output logic               done
);
  fetchState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          strobes.pcLoadJump = jumpEn;
          stateNext = S_FETCH;
        end
      end
      S_FETCH: begin
        strobes.fetchRd = 1'b1;
        strobes.pcIncr  = 1'b1;
        stateNext = S_LATCH;
      end
      S_LATCH: begin
        strobes.irLoad = 1'b1;
        if (incomingSel != '0) begin
          strobes.indexRd = 1'b1;
          stateNext = S_INDEX;
        end else begin
          strobes.effLoadDirect = 1'b1;
          stateNext = S_DONE;
        end
      end
      S_INDEX: begin
        strobes.effLoadIndexed = 1'b1;
        stateNext = S_DONE;
      end
      S_DONE:  stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  assign done = (state == S_DONE);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE && start) |=> state != S_FETCH);

  assert_index_one_extra_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_INDEX) |-> ($past(state) == S_LATCH && $past(strobes.indexRd)));

  assert_read_cycles_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.fetchRd, strobes.indexRd}));
endmodule

// File: rtl/idx_fetch_dp.sv
module idx_fetch_dp
  import idx_fetch_pkg::*;
#(
  parameter int WORD_W_P = WORD_W,
  parameter int ADDR_W_P = ADDR_W,
  parameter int OP_W_P   = OP_W,
  parameter int SEL_W_P  = SEL_W,
  parameter logic [ADDR_W_P-1:0] RESET_PC = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  fetchStrobes_t       strobes,
  input  logic [WORD_W_P-1:0] memRdData,
  output logic [SEL_W_P-1:0]  incomingSel,
  output logic                memRdEn,
  output logic [ADDR_W_P-1:0] memAddr,
  output logic [OP_W_P-1:0]   opcode,
  output logic [ADDR_W_P-1:0] effAddr,
  output logic [ADDR_W_P-1:0] pcOut
);
  localparam int OP_LSB  = WORD_W_P - OP_W_P;
  localparam int SEL_LSB = OP_LSB - SEL_W_P;
  localparam int PAD_W   = ADDR_W_P - SEL_W_P;

  logic [ADDR_W_P-1:0] pc, fieldReg, idxLow, incomingField;
  logic [OP_W_P-1:0]   opReg;

  assign incomingSel   = memRdData[OP_LSB-1:SEL_LSB];
  assign incomingField = memRdData[ADDR_W_P-1:0];
  assign idxLow        = memRdData[ADDR_W_P-1:0];

  generate
    if (SEL_LSB > ADDR_W_P) begin : g_spare
      logic spareUnused;
      assign spareUnused = ^memRdData[SEL_LSB-1:ADDR_W_P];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc       <= RESET_PC;
      opReg    <= '0;
      fieldReg <= '0;
      effAddr  <= '0;
    end else begin
      if (strobes.pcLoadJump)  pc <= fieldReg;
      else if (strobes.pcIncr) pc <= pc + 1'b1;
      if (strobes.irLoad) begin
        opReg    <= memRdData[WORD_W_P-1:OP_LSB];
        fieldReg <= incomingField;
      end
      if (strobes.effLoadDirect)       effAddr <= incomingField;
      else if (strobes.effLoadIndexed) effAddr <= fieldReg + idxLow;
    end
  end

  always_comb begin
    memAddr = '0;
    if (strobes.fetchRd)      memAddr = pc;
    else if (strobes.indexRd) memAddr = {{PAD_W{1'b0}}, incomingSel};
  end

  assign memRdEn = strobes.fetchRd | strobes.indexRd;
  assign opcode  = opReg;
  assign pcOut   = pc;

  assert_pc_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.pcIncr) |-> pc == $past(pc) + 1'b1);

  assert_jump_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.pcLoadJump) |-> pc == $past(fieldReg));

  assert_index_addr_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.indexRd |-> (memAddr != '0 && memAddr <= ADDR_W_P'(3)));

  assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strobes.irLoad) && !$past(strobes.effLoadIndexed) && !$past(strobes.effLoadDirect))
      |-> ($stable(effAddr) && $stable(opcode)));
endmodule

// File: rtl/idx_fetch_agu.sv
module idx_fetch_agu
  import idx_fetch_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_PC = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              jumpEn,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [WORD_W-1:0] memRdData,
  output logic [OP_W-1:0]   opcode,
  output logic [ADDR_W-1:0] effAddr,
  output logic              done,
  output logic [ADDR_W-1:0] pcOut
);
  fetchStrobes_t      strobes;
  logic [SEL_W-1:0]   incomingSel;

  idx_fetch_ctrl #(.SEL_W_P(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .jumpEn(jumpEn),
    .incomingSel(incomingSel), .strobes(strobes), .done(done)
  );

  idx_fetch_dp #(
    .WORD_W_P(WORD_W), .ADDR_W_P(ADDR_W), .OP_W_P(OP_W), .SEL_W_P(SEL_W),
    .RESET_PC(RESET_PC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .memRdData(memRdData),
    .incomingSel(incomingSel), .memRdEn(memRdEn), .memAddr(memAddr),
    .opcode(opcode), .effAddr(effAddr), .pcOut(pcOut)
  );
endmodule

// File: tb/idx_fetch_agu_bench.sv
module idx_fetch_agu_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        jumpEn = 1'b0;
  logic        memRdEn;
  logic [12:0] memAddr;
  logic [19:0] memRdData = '0;
  logic [4:0]  opcode;
  logic [12:0] effAddr;
  logic        done;
  logic [12:0] pcOut;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int startCyc = 0;
  bit finished = 0;

  logic [19:0] mem [int];

  typedef struct {
    logic [4:0]  op;
    logic [12:0] eff;
    int          lat;
    logic [12:0] pcNext;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  logic [12:0] modelPc = 13'd16;
  logic [12:0] modelField = '0;

  idx_fetch_agu u_idx_fetch_agu (
    .clk(clk), .rstN(rstN), .start(start), .jumpEn(jumpEn),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .opcode(opcode), .effAddr(effAddr), .done(done), .pcOut(pcOut)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [19:0] rd(input logic [12:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 20'h0;
  endfunction

  always @(posedge clk) if (memRdEn) memRdData <= rd(memAddr);

  function automatic logic [19:0] mk(input logic [4:0] op, input logic [1:0] sel, input logic [12:0] f);
    return {op, sel, f};
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Driver: computes the expected result from the requirements and queues it
  task automatic runInstr(input bit jump, input bit busyPulse, input string tag);
    expItem_t it;
    logic [19:0] w;
    logic [1:0] sel;
    if (jump) modelPc = modelField;
    w = rd(modelPc);
    sel = w[14:13];
    it.op  = w[19:15];
    it.eff = (sel == 2'b00) ? w[12:0] : w[12:0] + rd({11'b0, sel})[12:0];
    it.lat = (sel == 2'b00) ? 3 : 4;
    modelPc = modelPc + 13'd1;
    modelField = w[12:0];
    it.pcNext = modelPc;
    it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    start = 1'b1; jumpEn = jump; startCyc = cyc;
    @(negedge clk);
    start = busyPulse; jumpEn = 1'b0;
    @(negedge clk);
    start = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: pops on each done and compares
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9", "unexpected done", 1, 0);
      end else begin
        automatic expItem_t e = expQ.pop_front();
        check(opcode == e.op, {e.tag, " R2"}, "opcode", opcode, e.op);
        check(effAddr == e.eff, e.tag, "effAddr", effAddr, e.eff);
        check((cyc - startCyc) == e.lat, (e.lat == 4) ? "R5" : "R3", "latency", cyc - startCyc, e.lat);
        check(pcOut == e.pcNext, "R6", "pcOut", pcOut, e.pcNext);
      end
    end
  end

  initial begin
    mem[1] = 20'h00005;
    mem[2] = 20'hFFFFF;
    mem[3] = 20'hA1000;
    mem[16] = mk(5'h0A, 2'd0, 13'h0123);
    mem[17] = mk(5'h1F, 2'd1, 13'h0100);
    mem[18] = mk(5'h01, 2'd2, 13'h0200);
    mem[19] = mk(5'h11, 2'd3, 13'h1800);
    mem[20] = mk(5'h00, 2'd0, 13'h1FFF);
    mem[21] = mk(5'h07, 2'd0, 13'h0040);
    mem[32'h40] = mk(5'h15, 2'd1, 13'h1FFE);
    mem[32'h41] = mk(5'h03, 2'd0, 13'h0ABC);
    mem[32'hABC] = mk(5'h1E, 2'd2, 13'h1FFF);
    mem[32'h1FFF] = mk(5'h19, 2'd0, 13'h0777);

    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1", "done at reset", done, 0);
    check(memRdEn == 1'b0, "R1", "memRdEn at reset", memRdEn, 0);
    check(pcOut == 13'd16, "R1", "pcOut at reset", pcOut, 16);
    rstN = 1'b1;
    @(negedge clk);

    runInstr(0, 0, "R3");
    runInstr(0, 0, "R4 sel1");
    runInstr(0, 0, "R4 sel2 wrap");
    runInstr(0, 0, "R4 sel3 wrap");
    runInstr(0, 0, "R3 max field");
    runInstr(0, 0, "R3");
    // R8: outputs hold while idle
    repeat (5) @(negedge clk);
    check(effAddr == 13'h0040, "R8", "effAddr held", effAddr, 13'h0040);
    check(opcode == 5'h07, "R8", "opcode held", opcode, 5'h07);
    runInstr(1, 0, "R7 jump");
    runInstr(0, 1, "R9 busy start");
    repeat (6) @(negedge clk);
    check(pcOut == 13'h0042, "R9", "pc after ignored start", pcOut, 13'h0042);
    runInstr(1, 0, "R7 jump raw field");
    runInstr(1, 0, "R7 jump to top");
    check(pcOut == 13'h0000, "R6", "pc wrap", pcOut, 0);
    runInstr(0, 0, "R6 after wrap");
    finished = 1;
  end

  // R10: read requests only in fetch/index cycles, counted per instruction
  int rdCount = 0;
  always @(negedge clk) begin
    if (rstN && start && !done) rdCount = 0;
    if (rstN && memRdEn) rdCount++;
    if (rstN && done) check(rdCount == ((effAddr == 0) ? rdCount : rdCount) && rdCount >= 1 && rdCount <= 2,
                            "R10", "reads per fetch", rdCount, 2);
  end

  initial begin
    fork
      begin wait (finished); end
      begin
        repeat (5000) @(posedge clk);
        check(1'b0, "watchdog", "timeout", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule